// File: doc/BRIEF.md
# Fail-First Vector Length Controller

This block supervises the element accesses of a fail-first vector load or store and settles how many elements the operation finally covers. An operation opens with a one-cycle start strobe that carries the requested vector length, a flag telling whether the base address is a vector of indices, and two configuration bits: one forces every operation down to a single element, the other permits cutting the operation short where an element lands on the start of a cache line. Element requests then arrive one per cycle, each with its element number, its byte address and a fault indication from the memory system.

The first element of an operation is an ordinary access, so a fault on it raises an exception in the usual way and the length stays as requested. A fault on any later element is not reported as an exception. That access is cancelled instead, and the length shrinks to the number of elements already finished. The result can therefore never be zero. When alignment trimming is on, a later element whose address opens a new cache line is cancelled in the same way, so the next loop iteration starts on the line boundary. Combining fail-first with a vector-indexed base is illegal. Such a start is flagged and no operation is opened.

All outputs are registered. Each one reflects the start strobe or element request of the previous clock edge.

Top module: `ffvl_unit`

## Requirements
- R1: After reset, `raise_exc`, `cancel_acc`, `done`, `bad_mode` and `active` are 0 and `vl_out` is 0.
- R2: A faulting element number 0 gives `raise_exc`=1, `done`=1 and `cancel_acc`=0 one cycle later, with `vl_out` equal to the effective length, unchanged.
- R3: A faulting element k (k ≥ 1) gives `cancel_acc`=1, `done`=1 and `raise_exc`=0 one cycle later, with `vl_out`=k. A truncated length is never 0.
- R4: When every element 0..L-1 completes without fault, `done` pulses one cycle after element L-1 with `vl_out`=L. No earlier element produces any output pulse.
- R5: With `cfg_one`=1 at start, the effective length is 1. Element 0 completing without fault gives `done`=1 with `vl_out`=1.
- R6: A start with `op_vidx`=1 gives `bad_mode`=1 one cycle later, together with `active`=0 and `done`=0. Element requests that follow produce no output pulse.
- R7: With `cfg_align`=1 at start, an element k ≥ 1 whose address is a multiple of LINE_BYTES (64 by default) is cancelled with `vl_out`=k, as in R3. Element 0 is never trimmed. With `cfg_align`=0, addresses have no effect. A fault and a line boundary on the same element give a single cancel with `vl_out`=k.
- R8: Element requests are accepted only while `active`=1 and only when `el_num` equals the count of elements finished so far. Any other request is ignored and produces no pulse. `active` drops with `done`.
- R9: A requested length of 0 gives `done`=1 with `vl_out`=0 one cycle after the start. A requested length above MAX_VL (64 by default) is treated as MAX_VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Start strobe of a new fail-first operation |
| op_vl | input | VLW (7) | Requested vector length |
| op_vidx | input | 1 | Base address is a vector of indices (illegal with fail-first) |
| cfg_one | input | 1 | Force a single-element operation |
| cfg_align | input | 1 | Allow trimming at cache-line boundaries |
| el_valid | input | 1 | Element access request |
| el_num | input | VLW (7) | Element number of the request |
| el_addr | input | AW (32) | Byte address of the element |
| el_fault | input | 1 | Memory system reports a fault for this element |
| raise_exc | output | 1 | Pulse: raise the exception for the first element |
| cancel_acc | output | 1 | Pulse: the requested element access is cancelled |
| vl_out | output | VLW (7) | Final vector length of the last finished operation |
| done | output | 1 | Pulse: operation finished, `vl_out` valid |
| bad_mode | output | 1 | Pulse: illegal vector-indexed fail-first start |
| active | output | 1 | Operation open and accepting elements |

## Verification
Two truncation causes can hit the same element. A fault and a cache-line boundary can both apply to one request. Directed cases drive a faulting element at a line-start address, both at element 0 and at a later element. The bench expects a single exception with the length untouched in the first case, and a single cancel with the length equal to the element number in the second. Random operations mix faults, strides and alignment so that this overlap recurs. A reference function in the bench judges each element under the same rules.

// File: rtl/ffvl_pkg.sv
package ffvl_pkg;
  typedef enum logic [2:0] {
    RES_IDLE = 3'd0,  // no accepted request this cycle
    RES_PASS = 3'd1,  // element completed, more follow
    RES_LAST = 3'd2,  // element completed, operation complete
    RES_EXC  = 3'd3,  // first element faulted
    RES_CUT  = 3'd4   // later element cancelled, length trimmed
  } elem_res_e;
endpackage

// File: rtl/ffvl_clamp.sv
module ffvl_clamp #(
  parameter int MAX_VL = 64,
  parameter int VLW    = $clog2(MAX_VL + 1)
) (
  input  logic [VLW-1:0] req_vl,
  input  logic           one,
  output logic [VLW-1:0] eff_vl
);
  localparam logic [VLW-1:0] MAXV = VLW'(MAX_VL);
  localparam logic [VLW-1:0] ONEV = VLW'(1);

  always_comb begin
    if (req_vl == '0)      eff_vl = '0;
    else if (one)          eff_vl = ONEV;
    else if (req_vl > MAXV) eff_vl = MAXV;
    else                   eff_vl = req_vl;
  end
endmodule

// File: rtl/ffvl_judge.sv
module ffvl_judge #(
  parameter int VLW        = 7,
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic                busy,
  input  logic [VLW-1:0]      cnt,
  input  logic [VLW-1:0]      target,
  input  logic                align_en,
  input  logic                req_valid,
  input  logic [VLW-1:0]      req_num,
  input  logic [AW-1:0]       req_addr,
  input  logic                req_fault,
  output ffvl_pkg::elem_res_e res
);
  import ffvl_pkg::*;

  logic          on_line;
  logic          taken;
  logic          first;
  logic [VLW:0]  nxt;

  generate
    if (LINE_BYTES > 1) begin : g_line
      localparam logic [AW-1:0] LMASK = AW'(LINE_BYTES - 1);
      assign on_line = ((req_addr & LMASK) == '0);
    end else begin : g_noline
      assign on_line = 1'b0 & (|req_addr);
    end
  endgenerate

  assign taken = req_valid && busy && (req_num == cnt);
  assign first = (cnt == '0);
  assign nxt   = {1'b0, cnt} + {{VLW{1'b0}}, 1'b1};

  always_comb begin
    res = RES_IDLE;
    if (taken) begin
      if (first && req_fault)                            res = RES_EXC;
      else if (!first && (req_fault || (align_en && on_line))) res = RES_CUT;
      else if (nxt == {1'b0, target})                    res = RES_LAST;
      else                                               res = RES_PASS;
    end
  end
endmodule

// File: rtl/ffvl_ctrl.sv
module ffvl_ctrl #(
  parameter int MAX_VL = 64,
  parameter int VLW    = $clog2(MAX_VL + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                op_start,
  input  logic                op_vidx,
  input  logic [VLW-1:0]      eff_vl,
  input  logic                cfg_align,
  input  ffvl_pkg::elem_res_e res,
  output logic                busy,
  output logic [VLW-1:0]      cnt,
  output logic [VLW-1:0]      target,
  output logic                align_en,
  output logic                raise_exc,
  output logic                cancel_acc,
  output logic [VLW-1:0]      vl_out,
  output logic                done,
  output logic                bad_mode
);
  import ffvl_pkg::*;

  localparam logic [VLW-1:0] STEP = VLW'(1);
  localparam logic [VLW-1:0] MAXV = VLW'(MAX_VL);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      cnt        <= '0;
      target     <= '0;
      align_en   <= 1'b0;
      raise_exc  <= 1'b0;
      cancel_acc <= 1'b0;
      vl_out     <= '0;
      done       <= 1'b0;
      bad_mode   <= 1'b0;
    end else begin
      raise_exc  <= 1'b0;
      cancel_acc <= 1'b0;
      done       <= 1'b0;
      bad_mode   <= 1'b0;
      if (op_start) begin
        cnt <= '0;
        if (op_vidx) begin
          bad_mode <= 1'b1;
          busy     <= 1'b0;
        end else if (eff_vl == '0) begin
          done   <= 1'b1;
          vl_out <= '0;
          busy   <= 1'b0;
        end else begin
          busy     <= 1'b1;
          target   <= eff_vl;
          align_en <= cfg_align;
        end
      end else begin
        case (res)
          RES_EXC: begin
            raise_exc <= 1'b1;
            done      <= 1'b1;
            vl_out    <= target;
            busy      <= 1'b0;
          end
          RES_CUT: begin
            cancel_acc <= 1'b1;
            done       <= 1'b1;
            vl_out     <= cnt;
            busy       <= 1'b0;
          end
          RES_LAST: begin
            done   <= 1'b1;
            vl_out <= target;
            busy   <= 1'b0;
            cnt    <= cnt + STEP;
          end
          RES_PASS: cnt <= cnt + STEP;
          default: ;
        endcase
      end
    end
  end

  // R2: a first-element exception ends the operation and never cancels
  p_exc_ends_r2: assert property (@(posedge clk) disable iff (rst)
    raise_exc |-> (done && !cancel_acc));

  // R3: a cancelled access leaves a nonzero length
  p_cut_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    cancel_acc |-> (done && !raise_exc && (vl_out != '0)));

  // R4: an open operation never has counted past its length
  p_cnt_below_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < target));

  // R6: illegal start opens nothing
  p_bad_idle_r6: assert property (@(posedge clk) disable iff (rst)
    bad_mode |-> (!busy && !done));

  // R8: completion closes the operation
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9: final length never exceeds the maximum
  p_vl_max_r9: assert property (@(posedge clk) disable iff (rst)
    vl_out <= MAXV);
endmodule

// File: rtl/ffvl_unit.sv
module ffvl_unit #(
  parameter int MAX_VL     = 64,
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int VLW        = $clog2(MAX_VL + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_start,
  input  logic [VLW-1:0] op_vl,
  input  logic           op_vidx,
  input  logic           cfg_one,
  input  logic           cfg_align,
  input  logic           el_valid,
  input  logic [VLW-1:0] el_num,
  input  logic [AW-1:0]  el_addr,
  input  logic           el_fault,
  output logic           raise_exc,
  output logic           cancel_acc,
  output logic [VLW-1:0] vl_out,
  output logic           done,
  output logic           bad_mode,
  output logic           active
);
  import ffvl_pkg::*;

  logic [VLW-1:0] eff_vl;
  logic [VLW-1:0] cnt;
  logic [VLW-1:0] target;
  logic           align_en;
  elem_res_e      res;

  ffvl_clamp #(.MAX_VL(MAX_VL), .VLW(VLW)) u_clamp (
    .req_vl (op_vl),
    .one    (cfg_one),
    .eff_vl (eff_vl)
  );

  ffvl_judge #(.VLW(VLW), .AW(AW), .LINE_BYTES(LINE_BYTES)) u_judge (
    .busy      (active),
    .cnt       (cnt),
    .target    (target),
    .align_en  (align_en),
    .req_valid (el_valid),
    .req_num   (el_num),
    .req_addr  (el_addr),
    .req_fault (el_fault),
    .res       (res)
  );

  ffvl_ctrl #(.MAX_VL(MAX_VL), .VLW(VLW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .op_start   (op_start),
    .op_vidx    (op_vidx),
    .eff_vl     (eff_vl),
    .cfg_align  (cfg_align),
    .res        (res),
    .busy       (active),
    .cnt        (cnt),
    .target     (target),
    .align_en   (align_en),
    .raise_exc  (raise_exc),
    .cancel_acc (cancel_acc),
    .vl_out     (vl_out),
    .done       (done),
    .bad_mode   (bad_mode)
  );
endmodule

// File: tb/ffvl_unit_test.sv
module ffvl_unit_test;
  localparam int MAXV = 64;
  localparam int LINE = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_start = 1'b0;
  logic [6:0]  op_vl = '0;
  logic        op_vidx = 1'b0;
  logic        cfg_one = 1'b0;
  logic        cfg_align = 1'b0;
  logic        el_valid = 1'b0;
  logic [6:0]  el_num = '0;
  logic [31:0] el_addr = '0;
  logic        el_fault = 1'b0;
  logic        raise_exc, cancel_acc, done, bad_mode, active;
  logic [6:0]  vl_out;

  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  ffvl_unit uut (
    .clk(clk), .rst(rst), .op_start(op_start), .op_vl(op_vl), .op_vidx(op_vidx),
    .cfg_one(cfg_one), .cfg_align(cfg_align), .el_valid(el_valid), .el_num(el_num),
    .el_addr(el_addr), .el_fault(el_fault), .raise_exc(raise_exc),
    .cancel_acc(cancel_acc), .vl_out(vl_out), .done(done), .bad_mode(bad_mode),
    .active(active)
  );

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int effective(int vl, bit one);
    if (vl == 0) return 0;
    if (one) return 1;
    return (vl > MAXV) ? MAXV : vl;
  endfunction

  // pulses packed as {raise_exc, cancel_acc, done, bad_mode}
  function automatic int pulses();
    return {raise_exc, cancel_acc, done, bad_mode};
  endfunction

  task automatic start(int vl, bit vidx, bit one, bit al);
    @(negedge clk);
    op_start = 1'b1; op_vl = vl[6:0]; op_vidx = vidx; cfg_one = one; cfg_align = al;
    @(negedge clk);
    op_start = 1'b0; op_vidx = 1'b0;
  endtask

  task automatic elem(int k, int addr, bit flt);
    @(negedge clk);
    el_valid = 1'b1; el_num = k[6:0]; el_addr = addr; el_fault = flt;
    @(negedge clk);
    el_valid = 1'b0; el_fault = 1'b0;
  endtask

  // Runs one operation through the reference rules and checks every step
  task automatic run_op(int vl, bit one, bit al, int fpos, int base, int stride);
    int eff = effective(vl, one);
    start(vl, 1'b0, one, al);
    if (eff == 0) begin
      chk("R9 zero length pulses", pulses(), 4'b0010);
      chk("R9 zero length vl", vl_out, 0);
      return;
    end
    for (int k = 0; k < eff; k++) begin
      int  a  = base + k * stride;
      bit  f  = (k == fpos);
      bit  bd = al && (k > 0) && ((a % LINE) == 0);
      elem(k, a, f);
      if (k == 0 && f) begin
        chk("R2 first fault pulses", pulses(), 4'b1010);
        chk("R2 first fault vl", vl_out, eff);
        break;
      end else if (k > 0 && (f || bd)) begin
        chk(bd ? "R7 trim pulses" : "R3 later fault pulses", pulses(), 4'b0110);
        chk(bd ? "R7 trim vl" : "R3 later fault vl", vl_out, k);
        break;
      end else if (k == eff - 1) begin
        chk(one ? "R5 single done" : "R4 full done", pulses(), 4'b0010);
        chk(one ? "R5 single vl" : "R4 full vl", vl_out, eff);
      end else begin
        chk("R4 no early pulse", pulses(), 4'b0000);
      end
    end
    chk("R8 closed after op", active, 0);
  endtask

  initial begin
    #(200000 * 10);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset pulses", pulses(), 0);
    chk("R1 reset vl", vl_out, 0);
    chk("R1 reset active", active, 0);

    run_op(4, 0, 0, 99, 256, 8);        // R4 clean run
    run_op(5, 0, 0, 0, 256, 8);         // R2 first element fault
    run_op(6, 0, 0, 3, 256, 8);         // R3 fault at element 3
    run_op(8, 1, 0, 99, 256, 8);        // R5 single element
    run_op(8, 0, 1, 99, 48, 8);         // R7 trim at element 2 (addr 64)
    run_op(8, 0, 0, 99, 48, 8);         // R7 disabled: full length
    run_op(8, 0, 1, 2, 48, 8);          // R7 with R3 on the same element
    run_op(3, 0, 1, 0, 0, 8);           // R7 element 0 on line start, faulting
    run_op(3, 0, 1, 99, 0, 8);          // R7 element 0 never trimmed
    run_op(0, 0, 0, 99, 0, 8);          // R9 zero length
    run_op(100, 0, 0, 99, 4, 4);        // R9 clamp to 64

    // R6 illegal vector-indexed start
    start(4, 1'b1, 1'b0, 1'b0);
    chk("R6 bad pulses", pulses(), 4'b0001);
    chk("R6 not active", active, 0);
    elem(0, 0, 1'b1);
    chk("R6 element ignored", pulses(), 0);

    // R8 wrong element number ignored, then operation continues
    start(2, 1'b0, 1'b0, 1'b0);
    elem(1, 8, 1'b1);
    chk("R8 wrong number ignored", pulses(), 0);
    chk("R8 still active", active, 1);
    elem(0, 0, 1'b0);
    elem(1, 8, 1'b0);
    chk("R8 completes after skip", pulses(), 4'b0010);
    chk("R8 vl after skip", vl_out, 2);
    elem(2, 16, 1'b1);
    chk("R8 request after done ignored", pulses(), 0);
    chk("R8 vl held", vl_out, 2);

    for (int n = 0; n < 60; n++) begin
      int vl  = 1 + ($urandom % 10);
      bit one = (($urandom % 5) == 0);
      bit al  = $urandom % 2;
      int fp  = $urandom % 12;
      int bs  = ($urandom % 32) * 8;
      int sd  = 4 << ($urandom % 3);
      run_op(vl, one, al, fp, bs, sd);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule